// File: doc/BRIEF.md
# Redundant Bit-Write Filter

This block sits between a memory controller's write port and a nonvolatile cell array whose cells wear out with every programming pulse. Each accepted write request becomes a three-step sequence: the block reads the word currently stored at the target address, compares it with the incoming word, and programs only the bit positions whose value actually changes. Bits that would be rewritten with the value they already hold are never pulsed.

For energy accounting, the block reports two counts with every response. One is the number of bits that go from one to zero. The other is the number of bits that go from zero to one. The two are kept apart because the two programming directions cost different energy. The total cost of a write can then be computed outside as a fixed part, plus the read of the old word, plus a variable part taken from these counts. When the new word matches the stored word, no array write is issued at all, but the request still completes with a response.

The block handles one request at a time. The array read latency `RD_LAT` and the array write latency `WR_LAT` are parameters counted in clock cycles, with `RD_LAT >= 1` and `WR_LAT > RD_LAT`.

Top module: `bitflip_write_filter`

## Requirements
- R1: After reset, `req_ready` is 1, and `arr_rd_en`, `arr_wr_strobe`, `rsp_valid` and every bit of `arr_wr_mask` are 0.
- R2: Every accepted request causes exactly one array read, at the request's address, with `arr_rd_en` high for one cycle in the cycle right after acceptance. The read comes before any array write for that request.
- R3: During an array write, `arr_wr_mask` bit i is 1 exactly when stored bit i differs from new bit i. `arr_wr_addr` equals the request address and `arr_wr_data` equals the request word.
- R4: With `rsp_valid`, `rsp_fall_cnt` equals the number of positions where the stored bit is 1 and the new bit is 0, and `rsp_rise_cnt` equals the number where the stored bit is 0 and the new bit is 1.
- R5: If the new word equals the stored word, `arr_wr_strobe` never rises. `rsp_valid` still pulses, with both counts 0, in cycle RD_LAT+2 after the acceptance cycle.
- R6: `arr_wr_strobe` is a single-cycle pulse. The mask, address and data present at the strobe stay unchanged for exactly WR_LAT cycles starting with the strobe cycle. Outside those cycles `arr_wr_mask` is all zeros.
- R7: `req_ready` is 0 from the cycle after acceptance through the response cycle, and it is 1 again in the cycle after `rsp_valid`.
- R8: When at least one bit changes, `rsp_valid` pulses for one cycle in cycle RD_LAT+WR_LAT+2 after the acceptance cycle.
- R9: After the write, the array holds the new word. Bit positions that did not change were left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Write request address |
| req_data | input | DATA_W | Word to be stored |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_fall_cnt | output | CNT_W | Bits programmed from one to zero |
| rsp_rise_cnt | output | CNT_W | Bits programmed from zero to one |
| arr_rd_en | output | 1 | Array read request, one cycle |
| arr_rd_addr | output | ADDR_W | Array read address |
| arr_rd_data | input | DATA_W | Stored word, valid RD_LAT cycles after `arr_rd_en` |
| arr_wr_strobe | output | 1 | Array write start, one cycle |
| arr_wr_addr | output | ADDR_W | Array write address, held for WR_LAT cycles |
| arr_wr_data | output | DATA_W | Array write word, held for WR_LAT cycles |
| arr_wr_mask | output | DATA_W | Per-bit program enables, held for WR_LAT cycles |

## Verification
Suppose the read-wait counter is off by one cycle. The block then captures the array's idle-pattern output instead of the stored word. This shows at the ports at once: the strobe's mask and the reported counts are wrong, and the bench's array model ends up holding a word other than the one requested. A wrong state sequence shows up as a response arriving at a cycle other than RD_LAT+2 or RD_LAT+WR_LAT+2 after acceptance, or as a write held for a number of cycles other than WR_LAT. A wrong mask register shows within the same transaction, either as untouched bits that get altered or as changed bits that are missing from the array.

// File: rtl/bwf_pkg.sv
// Package: shared types for the redundant bit-write filter.
// Assumes nothing beyond SystemVerilog-2017 enum support.
package bwf_pkg;

    // Sequencer states: read old word, wait for it, program, respond
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_ISSUE = 3'd1,
        ST_RD_WAIT  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_RESP     = 3'd5
    } bwf_state_e;

endpackage

// File: rtl/bwf_popcount.sv
// Module: bwf_popcount
// Counts the ones in a W-bit vector. Purely combinational.
// Assumes OUT_W is wide enough to hold W.
module bwf_popcount #(
    parameter int W     = 32,
    parameter int OUT_W = $clog2(W + 1)
) (
    input  logic [W-1:0]     vec,
    output logic [OUT_W-1:0] count
);

    // Sum the bits one at a time
    always_comb begin
        count = '0;
        for (int i = 0; i < W; i++) begin
            count = count + OUT_W'(vec[i]);
        end
    end

endmodule

// File: rtl/bwf_diff.sv
// Module: bwf_diff
// Compares the stored word with the new word bit by bit.
// The XNOR marks bits that would be rewritten unchanged; its complement
// is the program mask. Also counts one-to-zero and zero-to-one transitions.
// Assumes both words are valid in the same cycle.
module bwf_diff #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_word,
    output logic [DATA_W-1:0] chg_mask,
    output logic [CNT_W-1:0]  fall_cnt,
    output logic [CNT_W-1:0]  rise_cnt,
    output logic              same_word
);

    logic [DATA_W-1:0] keep_bit;
    logic [DATA_W-1:0] fall_bit;
    logic [DATA_W-1:0] rise_bit;

    // One compare cell per bit position
    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        assign keep_bit[g] = ~(old_word[g] ^ new_word[g]);
        assign chg_mask[g] = ~keep_bit[g];
        assign fall_bit[g] = old_word[g] & ~new_word[g];
        assign rise_bit[g] = ~old_word[g] & new_word[g];
    end

    assign same_word = &keep_bit;

    bwf_popcount #(.W(DATA_W), .OUT_W(CNT_W)) u_fall_cnt (
        .vec   (fall_bit),
        .count (fall_cnt)
    );

    bwf_popcount #(.W(DATA_W), .OUT_W(CNT_W)) u_rise_cnt (
        .vec   (rise_bit),
        .count (rise_cnt)
    );

endmodule

// File: rtl/bwf_ctrl.sv
// Module: bwf_ctrl
// Sequencer for one request at a time: issue the read, wait RD_LAT
// cycles, then either skip straight to the response or program for
// WR_LAT cycles before responding.
// Assumes RD_LAT >= 1 and WR_LAT >= 2, with WR_LAT > RD_LAT.
module bwf_ctrl
    import bwf_pkg::*;
#(
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic same_word,
    output logic req_ready,
    output logic rd_en,
    output logic capture,
    output logic wr_strobe,
    output logic wr_active,
    output logic rsp_valid
);

    localparam int TMR_W = $clog2(WR_LAT + 1);

    bwf_state_e       state_q;
    logic [TMR_W-1:0] tmr_q;

    // Advance the sequence and load or count down the wait timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tmr_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) state_q <= ST_RD_ISSUE;
                end
                ST_RD_ISSUE: begin
                    state_q <= ST_RD_WAIT;
                    tmr_q   <= TMR_W'(RD_LAT - 1);
                end
                ST_RD_WAIT: begin
                    if (tmr_q == '0) begin
                        state_q <= same_word ? ST_RESP : ST_WR_PULSE;
                    end else begin
                        tmr_q <= tmr_q - 1'b1;
                    end
                end
                ST_WR_PULSE: begin
                    state_q <= ST_WR_HOLD;
                    tmr_q   <= TMR_W'(WR_LAT - 2);
                end
                ST_WR_HOLD: begin
                    if (tmr_q == '0) state_q <= ST_RESP;
                    else             tmr_q   <= tmr_q - 1'b1;
                end
                ST_RESP: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Decode the state into strobes
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rd_en     = (state_q == ST_RD_ISSUE);
        capture   = (state_q == ST_RD_WAIT) && (tmr_q == '0);
        wr_strobe = (state_q == ST_WR_PULSE);
        wr_active = (state_q == ST_WR_PULSE) || (state_q == ST_WR_HOLD);
        rsp_valid = (state_q == ST_RESP);
    end

    // R7: acceptance drops ready on the next cycle
    assert_accept_drops_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R7: ready comes back right after the response
    assert_ready_after_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

    // R6: the write strobe lasts a single cycle
    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> !wr_strobe);

    // R5/R8: the response is a single-cycle pulse
    assert_rsp_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/bitflip_write_filter.sv
// Module: bitflip_write_filter (top)
// Turns each write request into read-compare-conditional-write, so only
// the changed bits are programmed, and reports the transitions by direction.
// Assumes the array returns read data exactly RD_LAT cycles after the read
// strobe and needs its write inputs held for WR_LAT cycles.
module bitflip_write_filter #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8,
    parameter int RD_LAT = 2,
    parameter int WR_LAT = 6,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [CNT_W-1:0]  rsp_fall_cnt,
    output logic [CNT_W-1:0]  rsp_rise_cnt,
    output logic              arr_rd_en,
    output logic [ADDR_W-1:0] arr_rd_addr,
    input  logic [DATA_W-1:0] arr_rd_data,
    output logic              arr_wr_strobe,
    output logic [ADDR_W-1:0] arr_wr_addr,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic [DATA_W-1:0] arr_wr_mask
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] mask_q;
    logic [CNT_W-1:0]  fall_q;
    logic [CNT_W-1:0]  rise_q;

    logic [DATA_W-1:0] chg_mask;
    logic [CNT_W-1:0]  fall_cnt;
    logic [CNT_W-1:0]  rise_cnt;
    logic              same_word;
    logic              capture;
    logic              wr_active;

    bwf_ctrl #(.RD_LAT(RD_LAT), .WR_LAT(WR_LAT)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .same_word (same_word),
        .req_ready (req_ready),
        .rd_en     (arr_rd_en),
        .capture   (capture),
        .wr_strobe (arr_wr_strobe),
        .wr_active (wr_active),
        .rsp_valid (rsp_valid)
    );

    bwf_diff #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_diff (
        .old_word  (arr_rd_data),
        .new_word  (data_q),
        .chg_mask  (chg_mask),
        .fall_cnt  (fall_cnt),
        .rise_cnt  (rise_cnt),
        .same_word (same_word)
    );

    // Latch the request when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (req_valid && req_ready) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Keep the compare result once the old word arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            fall_q <= '0;
            rise_q <= '0;
        end else if (capture) begin
            mask_q <= chg_mask;
            fall_q <= fall_cnt;
            rise_q <= rise_cnt;
        end
    end

    assign arr_rd_addr  = addr_q;
    assign arr_wr_addr  = addr_q;
    assign arr_wr_data  = data_q;
    assign arr_wr_mask  = wr_active ? mask_q : '0;
    assign rsp_fall_cnt = fall_q;
    assign rsp_rise_cnt = rise_q;

    // Per-request history kept only for the properties below
    logic rd_seen_q;
    logic wr_seen_q;

    // Track whether this request has read and written the array
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_seen_q <= 1'b0;
            wr_seen_q <= 1'b0;
        end else if (rsp_valid) begin
            rd_seen_q <= 1'b0;
            wr_seen_q <= 1'b0;
        end else begin
            if (arr_rd_en)     rd_seen_q <= 1'b1;
            if (arr_wr_strobe) wr_seen_q <= 1'b1;
        end
    end

    // R2: a write never starts before this request's read
    assert_read_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_strobe |-> rd_seen_q);

    // R4: the two counts add up to the number of programmed bits
    assert_count_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (int'(rsp_fall_cnt) + int'(rsp_rise_cnt) == $countones(mask_q)));

    // R5: a response with no changed bits had no array write
    assert_skip_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fall_cnt == '0 && rsp_rise_cnt == '0) |-> !wr_seen_q);

    // R6: the write inputs stay put while the write is in progress
    assert_write_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_active && !arr_wr_strobe) |->
            ($stable(arr_wr_mask) && $stable(arr_wr_addr) && $stable(arr_wr_data)));

    // R6: no program enables outside a write
    assert_mask_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_active |-> (arr_wr_mask == '0));

endmodule

// File: tb/bitflip_write_filter_tb_top.sv
// Directed bench for bitflip_write_filter, with a behavioural array model.
module bitflip_write_filter_tb_top;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int RD_LAT = 2;
    localparam int WR_LAT = 6;
    localparam int CNT_W  = $clog2(DATA_W + 1);
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [DATA_W-1:0] IDLE_PATTERN = 32'hA5C3_5A3C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid;
    logic [CNT_W-1:0]  rsp_fall_cnt;
    logic [CNT_W-1:0]  rsp_rise_cnt;
    logic              arr_rd_en;
    logic [ADDR_W-1:0] arr_rd_addr;
    logic [DATA_W-1:0] arr_rd_data;
    logic              arr_wr_strobe;
    logic [ADDR_W-1:0] arr_wr_addr;
    logic [DATA_W-1:0] arr_wr_data;
    logic [DATA_W-1:0] arr_wr_mask;

    int vectors = 0;
    int fails   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitflip_write_filter #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT), .WR_LAT(WR_LAT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_fall_cnt(rsp_fall_cnt), .rsp_rise_cnt(rsp_rise_cnt),
        .arr_rd_en(arr_rd_en), .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data),
        .arr_wr_strobe(arr_wr_strobe), .arr_wr_addr(arr_wr_addr),
        .arr_wr_data(arr_wr_data), .arr_wr_mask(arr_wr_mask)
    );

    // Array model: fixed read latency, masked write on the strobe
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_pipe [RD_LAT];

    always @(posedge clk) begin
        rd_pipe[0] <= arr_rd_en ? mem[arr_rd_addr] : IDLE_PATTERN;
        for (int i = 1; i < RD_LAT; i++) rd_pipe[i] <= rd_pipe[i-1];
        if (arr_wr_strobe)
            mem[arr_wr_addr] <= (mem[arr_wr_addr] & ~arr_wr_mask) | (arr_wr_data & arr_wr_mask);
    end
    assign arr_rd_data = rd_pipe[RD_LAT-1];

    // Port monitor, sampled on the falling edge
    int                cyc_g = 0;
    int                rd_count, wr_count, rd_cyc, wr_cyc, hold_cycles, unstable;
    logic [ADDR_W-1:0] rd_addr_seen, wr_addr_seen;
    logic [DATA_W-1:0] wr_mask_seen, wr_data_seen;

    always @(negedge clk) begin
        cyc_g <= cyc_g + 1;
        if (arr_rd_en) begin
            rd_count     <= rd_count + 1;
            rd_cyc       <= cyc_g;
            rd_addr_seen <= arr_rd_addr;
        end
        if (arr_wr_strobe) begin
            wr_count     <= wr_count + 1;
            wr_cyc       <= cyc_g;
            wr_mask_seen <= arr_wr_mask;
            wr_data_seen <= arr_wr_data;
            wr_addr_seen <= arr_wr_addr;
            hold_cycles  <= 1;
        end else if (arr_wr_mask != '0) begin
            hold_cycles <= hold_cycles + 1;
            if (arr_wr_mask != wr_mask_seen || arr_wr_data != wr_data_seen ||
                arr_wr_addr != wr_addr_seen)
                unstable <= unstable + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write through the block, with every per-transaction check
    task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] old_w;
        int  exp_fall, exp_rise, exp_lat, lat, busy_ready;
        bit  changed;
        old_w    = mem[a];
        exp_fall = $countones(old_w & ~d);
        exp_rise = $countones(~old_w & d);
        changed  = (old_w != d);
        exp_lat  = changed ? RD_LAT + WR_LAT + 2 : RD_LAT + 2;
        @(negedge clk);
        rd_count = 0; wr_count = 0; unstable = 0; hold_cycles = 0;
        check(req_ready == 1'b1, "R7 ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1; busy_ready = 0;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_ready++;
            @(negedge clk);
            lat++;
        end
        check(busy_ready == 0, "R7 ready low while busy", busy_ready, 0);
        check(lat == exp_lat, changed ? "R8 response latency" : "R5 response latency", lat, exp_lat);
        check(int'(rsp_fall_cnt) == exp_fall, "R4 one-to-zero count", rsp_fall_cnt, exp_fall);
        check(int'(rsp_rise_cnt) == exp_rise, "R4 zero-to-one count", rsp_rise_cnt, exp_rise);
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R7 ready after response", req_ready, 1);
        check(rd_count == 1, "R2 single array read", rd_count, 1);
        check(rd_addr_seen == a, "R2 read address", rd_addr_seen, a);
        if (changed) begin
            check(wr_count == 1, "R6 single write strobe", wr_count, 1);
            check(rd_cyc < wr_cyc, "R2 read before write", rd_cyc, wr_cyc);
            check(wr_mask_seen == (old_w ^ d), "R3 program mask", wr_mask_seen, old_w ^ d);
            check(wr_data_seen == d && wr_addr_seen == a, "R3 write data/address", wr_data_seen, d);
            check(hold_cycles == WR_LAT, "R6 write hold length", hold_cycles, WR_LAT);
            check(unstable == 0, "R6 write inputs stable", unstable, 0);
        end else begin
            check(wr_count == 0, "R5 no write for equal word", wr_count, 0);
        end
        check(arr_wr_mask == '0, "R6 mask zero after write", arr_wr_mask, 0);
        check(mem[a] == d, "R9 array holds new word", mem[a], d);
    endtask

    task automatic t_reset_state();
        check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
        check(arr_rd_en == 1'b0 && arr_wr_strobe == 1'b0, "R1 no array access", {arr_rd_en, arr_wr_strobe}, 0);
        check(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
        check(arr_wr_mask == '0, "R1 mask zero", arr_wr_mask, 0);
    endtask

    task automatic t_invert_all();     do_write(8'h10, ~mem[8'h10]);               endtask
    task automatic t_single_bit();     do_write(8'h21, mem[8'h21] ^ 32'h0000_8000); endtask
    task automatic t_equal_word();     do_write(8'h33, mem[8'h33]);                endtask
    task automatic t_only_rises();     mem[8'h44] = 32'h0; do_write(8'h44, 32'hF0F0_1234); endtask
    task automatic t_only_falls();     mem[8'h55] = 32'hFFFF_FFFF; do_write(8'h55, 32'h7FFE_0001); endtask
    task automatic t_mixed();          do_write(8'hFF, 32'h1357_9BDF);             endtask
    task automatic t_rewrite_chain();
        do_write(8'h10, 32'hDEAD_BEEF);
        do_write(8'h10, 32'hDEAD_BEEF);
        do_write(8'h10, 32'h0000_0000);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(i) * 32'h9E37_79B1;
        for (int i = 0; i < RD_LAT; i++) rd_pipe[i] = IDLE_PATTERN;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_invert_all();
        t_single_bit();
        t_equal_word();
        t_only_rises();
        t_only_falls();
        t_mixed();
        t_rewrite_chain();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule